// File: doc/BRIEF.md
# Buffered-Duty PWM Channel

A single pulse-width-modulated output channel built around a compare counter. A register port writes a duty value, and the same port reads back that value. A period input and a mode input choose between two waveform shapes. In edge mode the counter ramps up and wraps. In symmetric mode the counter rises and then falls, which places each pulse at the centre of the cycle. A polarity input selects the level that the output holds during the "on" part of each cycle.

A duty write made while the channel runs goes to a holding register first. It only reaches the compare stage at the boundary between two cycles. The period and the mode follow the same rule. As a result, reprogramming never produces a shortened or malformed cycle. While the channel is disabled, the counter rests at zero, the output holds the inactive level, and configuration passes straight through. Turning the channel on always begins a complete cycle.

Top module: `pwm_chan`

## Requirements
- R1: After reset, the duty readback is 0xFF. With `en` low, `pwm_out` equals the inverse of `pol`.
- R2: One cycle after a write, `duty_rdata` returns the value written, whether or not that value is in use yet.
- R3: While `en` is low, the counter stays at zero and `pwm_out` equals `!pol` one clock later. A duty value written while disabled is applied directly. A value held in the buffer is applied when the channel is disabled.
- R4: Edge mode (`align`=0). A cycle lasts `period`+1 clocks. `pwm_out` equals `pol` for the first `duty`+1 clocks and `!pol` for the rest.
- R5: Symmetric mode (`align`=1). A cycle lasts 2·`period` clocks. The counter ascends from 0 to `period`−1 and then descends over the same values. `pwm_out` equals `pol` while the count is below `duty`, which gives `duty` clocks at each end of the cycle.
- R6: A duty write made while `en` is high leaves the current cycle unchanged. The new value takes effect from the first clock of the next cycle.
- R7: When the active duty is at or above the active period, `pwm_out` stays at `pol` for the whole cycle.
- R8: An active duty of 0xFF holds `pwm_out` at `!pol`, overriding R7.
- R9: A change of `period` or `align` while running leaves the current cycle intact. The change applies from the next cycle.
- R10: The first clock edge that samples `en` high begins a full cycle at count zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Channel enable |
| align | input | 1 | 0 = edge mode, 1 = symmetric mode |
| pol | input | 1 | Level driven during the "on" part of the cycle |
| period | input | 8 | Period value |
| duty_we | input | 1 | Duty write strobe |
| duty_wdata | input | 8 | Duty write data |
| duty_rdata | output | 8 | Last duty value written |
| pwm_out | output | 1 | PWM output |

## Verification
The output checks compare `pwm_out` with the `pol` of the previous cycle, so they assume no other input is indeterminate. The counter bounds assume a period of at least one clock in symmetric mode. The stimulus changes every input only on falling clock edges. It keeps `period` nonzero. It never writes the duty in the same cycle as a rollover, so it does not depend on how such a collision is resolved.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;

    typedef enum logic {
        ALN_EDGE   = 1'b0,
        ALN_CENTER = 1'b1
    } align_e;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    // Output level for a counter value; all-ones duty forces the inactive level.
    function automatic logic pwm_level(align_e m, int unsigned c, int unsigned d,
                                       int unsigned dmax, logic pol);
        logic on;
        if (d == dmax) return ~pol;
        on = (m == ALN_EDGE) ? (c <= d) : (c < d);
        return on ? pol : ~pol;
    endfunction

endpackage

// File: rtl/pwm_chan_counter.sv
module pwm_chan_counter
    import pwm_chan_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  align_e        align_i,
    input  logic [DW-1:0] period_i,
    output logic          roll_o,
    output logic [DW-1:0] nxt_cnt_o,
    output align_e        nxt_mode_o
);
    logic [DW-1:0] cnt_q, nxt_cnt, per_q, nxt_per;
    dir_e          dir_q, nxt_dir;
    align_e        mode_q, nxt_mode;
    logic          run_q, nxt_run, roll;

    always_comb begin
        nxt_cnt  = cnt_q;
        nxt_dir  = dir_q;
        nxt_run  = run_q;
        nxt_per  = per_q;
        nxt_mode = mode_q;
        roll     = 1'b0;
        if (!en) begin
            nxt_cnt  = '0;
            nxt_dir  = DIR_UP;
            nxt_run  = 1'b0;
            nxt_per  = period_i;
            nxt_mode = align_i;
        end else if (!run_q) begin
            nxt_cnt = '0;
            nxt_dir = DIR_UP;
            nxt_run = 1'b1;
        end else begin
            if (mode_q == ALN_EDGE) begin
                if (cnt_q >= per_q) roll = 1'b1;
                else                nxt_cnt = cnt_q + 1'b1;
            end else if (per_q == '0) begin
                roll = 1'b1;
            end else if (dir_q == DIR_UP) begin
                if (cnt_q >= per_q - 1'b1) nxt_dir = DIR_DOWN;
                else                       nxt_cnt = cnt_q + 1'b1;
            end else begin
                if (cnt_q == '0) roll = 1'b1;
                else             nxt_cnt = cnt_q - 1'b1;
            end
            if (roll) begin
                nxt_cnt  = '0;
                nxt_dir  = DIR_UP;
                nxt_per  = period_i;
                nxt_mode = align_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            dir_q  <= DIR_UP;
            run_q  <= 1'b0;
            per_q  <= '0;
            mode_q <= ALN_EDGE;
        end else begin
            cnt_q  <= nxt_cnt;
            dir_q  <= nxt_dir;
            run_q  <= nxt_run;
            per_q  <= nxt_per;
            mode_q <= nxt_mode;
        end
    end

    assign roll_o     = roll;
    assign nxt_cnt_o  = nxt_cnt;
    assign nxt_mode_o = nxt_mode;

    AST_EDGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (run_q && mode_q == ALN_EDGE) |-> (cnt_q <= per_q)); // R4
    AST_CENTER_BOUND: assert property (@(posedge clk) disable iff (rst)
        (run_q && mode_q == ALN_CENTER && per_q != '0) |-> (cnt_q < per_q)); // R5
    AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0 && !run_q)); // R3
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (run_q && en && !roll) |=> ($stable(per_q) && $stable(mode_q))); // R9
endmodule

// File: rtl/pwm_chan_duty.sv
module pwm_chan_duty #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          roll_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic [DW-1:0] nxt_act_o
);
    localparam logic [DW-1:0] RST_VAL = '1;

    logic [DW-1:0] buf_q, act_q, nxt_buf, nxt_act;

    always_comb begin
        nxt_buf = we_i ? wdata_i : buf_q;
        nxt_act = (!en || roll_i) ? nxt_buf : act_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= RST_VAL;
            act_q <= RST_VAL;
        end else begin
            buf_q <= nxt_buf;
            act_q <= nxt_act;
        end
    end

    assign rdata_o   = buf_q;
    assign nxt_act_o = nxt_act;

    AST_READBACK: assert property (@(posedge clk) disable iff (rst)
        we_i |=> (rdata_o == $past(wdata_i))); // R2
    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !roll_i) |=> $stable(act_q)); // R6
endmodule

// File: rtl/pwm_chan_wave.sv
module pwm_chan_wave
    import pwm_chan_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          pol,
    input  align_e        mode_i,
    input  logic [DW-1:0] cnt_i,
    input  logic [DW-1:0] duty_i,
    output logic          out_o
);
    localparam int unsigned DMAX = (1 << DW) - 1;

    logic lvl;

    always_comb begin
        if (!en) lvl = ~pol;
        else     lvl = pwm_level(mode_i, int'(cnt_i), int'(duty_i), DMAX, pol);
    end

    always_ff @(posedge clk) begin
        if (rst) out_o <= ~pol;
        else     out_o <= lvl;
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_chan_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          align,
    input  logic          pol,
    input  logic [DW-1:0] period,
    input  logic          duty_we,
    input  logic [DW-1:0] duty_wdata,
    output logic [DW-1:0] duty_rdata,
    output logic          pwm_out
);
    logic          roll;
    logic [DW-1:0] nxt_cnt, nxt_act;
    align_e        nxt_mode;

    pwm_chan_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst(rst), .en(en), .align_i(align_e'(align)),
        .period_i(period), .roll_o(roll), .nxt_cnt_o(nxt_cnt),
        .nxt_mode_o(nxt_mode)
    );

    pwm_chan_duty #(.DW(DW)) u_duty (
        .clk(clk), .rst(rst), .en(en), .roll_i(roll), .we_i(duty_we),
        .wdata_i(duty_wdata), .rdata_o(duty_rdata), .nxt_act_o(nxt_act)
    );

    pwm_chan_wave #(.DW(DW)) u_wave (
        .clk(clk), .rst(rst), .en(en), .pol(pol), .mode_i(nxt_mode),
        .cnt_i(nxt_cnt), .duty_i(nxt_act), .out_o(pwm_out)
    );

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !en |=> (pwm_out == !$past(pol))); // R3
    AST_FULL_DUTY_OFF: assert property (@(posedge clk) disable iff (rst)
        (en && nxt_act == '1) |=> (pwm_out == !$past(pol))); // R8
endmodule

// File: tb/pwm_chan_test.sv
module pwm_chan_test;
    logic       clk = 1'b0;
    logic       rst, en, align, pol, duty_we, pwm_out;
    logic [7:0] period, duty_wdata, duty_rdata;

    always #4 clk = ~clk;

    pwm_chan uut (
        .clk(clk), .rst(rst), .en(en), .align(align), .pol(pol),
        .period(period), .duty_we(duty_we), .duty_wdata(duty_wdata),
        .duty_rdata(duty_rdata), .pwm_out(pwm_out)
    );

    typedef struct {
        logic  val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0;
    int   n_err = 0;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected output bits of one full cycle, pushed into the scoreboard.
    task automatic push_period(logic m, int per, int d, logic p, string tag);
        exp_t e;
        int   n;
        n = m ? 2 * per : per + 1;
        for (int i = 0; i < n; i++) begin
            logic on;
            if (m) on = (i < d) || (i >= 2 * per - d);
            else   on = (i <= d);
            e.val = (d == 255) ? ~p : (on ? p : ~p);
            e.tag = tag;
            q.push_back(e);
        end
    endtask

    // Monitor: pops one expected bit per clock, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.tag, {7'd0, pwm_out}, {7'd0, e.val});
            end
        end
    end

    task automatic stop_and_check(logic p);
        wait (q.size() == 0);
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R3", {7'd0, pwm_out}, {7'd0, ~p});
    endtask

    task automatic start_run(logic m, int per, int d, logic p, int nper, string tag);
        period     = per[7:0];
        align      = m;
        pol        = p;
        duty_we    = 1'b1;
        duty_wdata = d[7:0];
        @(negedge clk);
        duty_we = 1'b0;
        check("R2", duty_rdata, d[7:0]);
        check("R3", {7'd0, pwm_out}, {7'd0, ~p});
        en = 1'b1;
        for (int k = 0; k < nper; k++) push_period(m, per, d, p, tag);
        stop_and_check(p);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst = 1'b1; en = 1'b0; align = 1'b0; pol = 1'b1;
        period = 8'd9; duty_we = 1'b0; duty_wdata = 8'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", duty_rdata, 8'hFF);
        check("R1", {7'd0, pwm_out}, 8'd0);

        // Buffered update, then period and mode change across rollovers.
        duty_we = 1'b1; duty_wdata = 8'd3;
        @(negedge clk);
        duty_we = 1'b0;
        check("R2", duty_rdata, 8'd3);
        check("R3", {7'd0, pwm_out}, 8'd0);
        en = 1'b1;
        push_period(1'b0, 9, 3, 1'b1, "R10");
        push_period(1'b0, 9, 6, 1'b1, "R6");
        push_period(1'b1, 4, 1, 1'b1, "R9");
        push_period(1'b1, 4, 1, 1'b1, "R9");
        repeat (4) @(negedge clk);
        duty_we = 1'b1; duty_wdata = 8'd6;
        @(negedge clk);
        duty_we = 1'b0;
        check("R2", duty_rdata, 8'd6);
        repeat (7) @(negedge clk);
        period = 8'd4; align = 1'b1; duty_we = 1'b1; duty_wdata = 8'd1;
        @(negedge clk);
        duty_we = 1'b0;
        stop_and_check(1'b1);

        start_run(1'b0, 4, 0, 1'b1, 2, "R4");
        start_run(1'b0, 6, 2, 1'b0, 2, "R4");
        start_run(1'b1, 6, 2, 1'b0, 2, "R5");
        start_run(1'b1, 5, 3, 1'b1, 2, "R5");
        start_run(1'b0, 7, 7, 1'b0, 1, "R7");
        start_run(1'b0, 5, 9, 1'b1, 1, "R7");
        start_run(1'b1, 3, 3, 1'b1, 1, "R7");
        start_run(1'b0, 6, 255, 1'b1, 1, "R8");
        start_run(1'b1, 5, 255, 1'b0, 1, "R8");

        // Buffered value handed to the compare stage by disabling.
        start_run(1'b0, 9, 2, 1'b1, 1, "R4");
        en = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        duty_we = 1'b1; duty_wdata = 8'd5;
        @(negedge clk);
        duty_we = 1'b0; en = 1'b0;
        @(negedge clk);
        check("R3", {7'd0, pwm_out}, 8'd0);
        en = 1'b1;
        push_period(1'b0, 9, 5, 1'b1, "R3");
        push_period(1'b0, 9, 5, 1'b1, "R3");
        stop_and_check(1'b1);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule